// File: doc/BRIEF.md
# Signal-change timestamp engine

This block watches a set of input lines for level changes and time-stamps each change. The lines are grouped in 32-line slices, and the number of slices is set per instance. When an enabled line changes level, the engine builds a record. The record holds the value of a shared free-running system time input, the index of the line and the new level of the line. The record goes into an internal FIFO.

Software works through a small word-addressed register port. It enables lines one bit per line, with one 32-bit enable word per slice. It sets an occupancy threshold that drives a level interrupt. It drains records by reading two timestamp words and then an info word; the read of the info word removes the record. If several enabled lines change in the same cycle, each change is held as pending and pushed one per cycle, lowest line index first. When the FIFO is full, records are discarded and a sticky overflow flag is set. Software clears that flag by writing 1 to it.

Register map (word addresses): 0 status, 1 threshold, 2 timestamp bits 31:0 of the head record, 3 timestamp bits 63:32 of the head record, 4 info (pops), 16+k enable word of slice k.

Top module: `sig_tstamp_engine`

## Requirements
- R1: After reset the FIFO is empty, `irq` is low, every enable word reads 0, the threshold reads 1, and status (address 0) reads 32'h0000_0002.
- R2: A level change on an enabled line pushes exactly one record. The line passes through two synchroniser flops and a compare flop. The record's timestamp is the `sys_time` value that `sys_time` holds during the clock cycle before the fourth rising edge after the change is applied. The info word (address 4) carries the line index in bits 15:0 and a 1 in bit 31.
- R3: Both rising and falling changes are recorded. Info bit 16 gives the new level (1 = rose, 0 = fell).
- R4: Bit j of the enable word at address 16+k enables line 32*k+j. A change on a line whose bit is 0 produces no record. Enable words read back as written.
- R5: Changes on several enabled lines in the same cycle are pushed in ascending line-index order, one per clock. Their timestamps therefore rise by one per record when `sys_time` counts once per clock.
- R6: A record that arrives while the FIFO holds FIFO_DEPTH records is discarded and sets status bit 0. A write to address 0 with bit 0 = 1 clears that bit. A write with bit 0 = 0 leaves it unchanged.
- R7: The threshold (address 1, bits 8:0) accepts only the values 1 to 256, and any other write leaves it unchanged. `irq` is high exactly while the FIFO count is at or above the threshold. Status bit 2 mirrors `irq`.
- R8: A read of address 4 pops the head record. Reads of addresses 2 and 3 do not pop. A read of address 4 with the FIFO empty returns 0 and changes nothing.
- R9: Status bit 1 is 1 when the FIFO is empty, and status bits 31:16 give the FIFO count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_SLICES*32 | Monitored lines, asynchronous to clk |
| sys_time | input | TS_W | Shared free-running system time value |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle; pops when the address is 4 |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Level interrupt, high while count >= threshold |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high together. They also assume that `sys_time` moves forward by exactly one each clock, so that per-record timestamp spacing is meaningful. The bench keeps to this by driving one strobe at a time for one cycle only, and by running `sys_time` as its own counter. Line changes are applied at the falling clock edge and held for many cycles. No change is therefore shorter than the synchroniser can see, and every expected timestamp can be counted from the drive cycle.

// File: rtl/ste_pkg.sv
// Package: shared constants for the signal-change timestamp engine.
// Assumes word addressing on a 32-bit register port.
package ste_pkg;
    localparam int SLICE_W   = 32;
    localparam int THR_MAX   = 256;
    localparam int A_STATUS  = 0;
    localparam int A_THRESH  = 1;
    localparam int A_TS_LO   = 2;
    localparam int A_TS_HI   = 3;
    localparam int A_INFO    = 4;
    localparam int A_EN_BASE = 16;
endpackage

// File: rtl/ste_line_front.sv
// Module: line front end. Syncs every line through two flops, finds level
// changes against a third flop, and keeps a sticky pending bit plus the
// latest level per enabled line. Assumes en and clr are in the clk domain.
module ste_line_front #(
    parameter int NUM_LINES = 96
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] pending,
    output logic [NUM_LINES-1:0] level
);
    logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q, pend_q, lvl_q;
    logic [NUM_LINES-1:0] chg;

    // Purpose: enabled level changes seen this cycle.
    always_comb chg = (sync2_q ^ prev_q) & en;

    // Purpose: synchroniser, compare stage, sticky pending and level capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
            pend_q  <= '0;
            lvl_q   <= '0;
        end else begin
            sync1_q <= line_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            pend_q  <= ((pend_q & ~clr) | chg) & en;
            lvl_q   <= (chg & sync2_q) | (~chg & lvl_q);
        end
    end

    assign pending = pend_q;
    assign level   = lvl_q;
endmodule

// File: rtl/ste_prio_pick.sv
// Module: lowest-index-first picker. Purely combinational; returns the
// index of the lowest set request and a one-hot grant for it.
module ste_prio_pick #(
    parameter int NUM_LINES = 96,
    parameter int IDX_W     = 7
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] grant
);
    // Purpose: scan downward so the lowest set request wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Purpose: one-hot grant for the chosen line.
    always_comb grant = any ? (NUM_LINES'(1) << idx) : '0;
endmodule

// File: rtl/ste_fifo.sv
// Module: record FIFO with occupancy count. Assumes DEPTH is a power of two.
// A push while full and a pop while empty are ignored.
module ste_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Purpose: storage write, no reset needed on the data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Purpose: pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sig_tstamp_engine.sv
// Module: signal-change timestamp engine top. Holds the enable slices, the
// threshold and overflow registers and the register read mux. It connects
// the line front end, the picker and the record FIFO. Assumes sys_time is
// already in the clk domain and that NUM_SLICES is 3, 11 or 17.
module sig_tstamp_engine
    import ste_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int TS_W       = 64,
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] line_in,
    input  logic [TS_W-1:0]             sys_time,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        irq
);
    localparam int NUM_LINES = NUM_SLICES * SLICE_W;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int REC_W     = TS_W + IDX_W + 1;
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);

    logic [SLICE_W-1:0]   en_slice [NUM_SLICES];
    logic [NUM_LINES-1:0] en_vec, pending, level, grant;
    logic [8:0]           thresh;
    logic                 ovf;
    logic                 pick_any, push, pop;
    logic [IDX_W-1:0]     pick_idx;
    logic [REC_W-1:0]     wr_rec, head_rec;
    logic [CNT_W-1:0]     fifo_count;
    logic                 fifo_full, fifo_empty;
    logic [63:0]          head_ts;
    logic [IDX_W-1:0]     head_idx;
    logic                 head_lvl;
    logic                 wr_status, wr_thresh, thresh_ok;

    // Purpose: flatten the per-slice enable words into one line vector.
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_en_flat
        assign en_vec[s*SLICE_W +: SLICE_W] = en_slice[s];
    end

    assign wr_status = reg_wr && (reg_addr == ADDR_W'(A_STATUS));
    assign wr_thresh = reg_wr && (reg_addr == ADDR_W'(A_THRESH));
    assign thresh_ok = (reg_wdata != 32'd0) && (reg_wdata <= 32'(THR_MAX));

    // Purpose: enable slice registers, one word per slice address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLICES; s++) en_slice[s] <= '0;
        end else if (reg_wr) begin
            for (int s = 0; s < NUM_SLICES; s++) begin
                if (reg_addr == ADDR_W'(A_EN_BASE + s)) en_slice[s] <= reg_wdata;
            end
        end
    end

    // Purpose: threshold register, accepting only legal values.
    always_ff @(posedge clk) begin
        if (!rst_n)                      thresh <= 9'd1;
        else if (wr_thresh && thresh_ok) thresh <= reg_wdata[8:0];
    end

    // Purpose: sticky overflow flag; a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ovf <= 1'b0;
        else if (pick_any && fifo_full)    ovf <= 1'b1;
        else if (wr_status && reg_wdata[0]) ovf <= 1'b0;
    end

    ste_line_front #(.NUM_LINES(NUM_LINES)) front_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .en      (en_vec),
        .clr     (grant),
        .pending (pending),
        .level   (level)
    );

    ste_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) pick_i (
        .req   (pending),
        .any   (pick_any),
        .idx   (pick_idx),
        .grant (grant)
    );

    assign push   = pick_any;
    assign pop    = reg_rd && (reg_addr == ADDR_W'(A_INFO)) && !fifo_empty;
    assign wr_rec = {sys_time, pick_idx, level[pick_idx]};

    ste_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wr_rec),
        .rdata (head_rec),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign head_lvl = head_rec[0];
    assign head_idx = head_rec[IDX_W:1];
    assign head_ts  = 64'(head_rec[REC_W-1 -: TS_W]);

    // Purpose: level interrupt on occupancy at or above threshold.
    always_comb irq = (10'(fifo_count) >= 10'(thresh));

    // Purpose: register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_STATUS): begin
                reg_rdata[0]     = ovf;
                reg_rdata[1]     = fifo_empty;
                reg_rdata[2]     = irq;
                reg_rdata[31:16] = 16'(fifo_count);
            end
            ADDR_W'(A_THRESH): reg_rdata = 32'(thresh);
            ADDR_W'(A_TS_LO):  reg_rdata = fifo_empty ? 32'd0 : head_ts[31:0];
            ADDR_W'(A_TS_HI):  reg_rdata = fifo_empty ? 32'd0 : head_ts[63:32];
            ADDR_W'(A_INFO): begin
                if (!fifo_empty) begin
                    reg_rdata[31]   = 1'b1;
                    reg_rdata[16]   = head_lvl;
                    reg_rdata[15:0] = 16'(head_idx);
                end
            end
            default: begin
                for (int s = 0; s < NUM_SLICES; s++) begin
                    if (reg_addr == ADDR_W'(A_EN_BASE + s)) reg_rdata = en_slice[s];
                end
            end
        endcase
    end
endmodule

// File: rtl/ste_checker.sv
// Module: property checker for the timestamp engine, bound to the top.
// Assumes a single clock and the top's synchronous active-low reset.
module ste_checker #(
    parameter int NUM_LINES  = 96,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CNT_W-1:0]     fifo_count,
    input logic                 fifo_full,
    input logic                 fifo_empty,
    input logic                 pick_any,
    input logic                 pop,
    input logic [NUM_LINES-1:0] grant,
    input logic                 ovf,
    input logic                 irq,
    input logic [8:0]           thresh
);
    // R7
    thresh_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh >= 9'd1) && (thresh <= 9'd256));

    // R7
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !fifo_empty);

    // R6
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_any && fifo_full) |=> ovf);

    // R6
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop) |=> fifo_full);

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(FIFO_DEPTH));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !pick_any) |=> fifo_empty);
endmodule

bind sig_tstamp_engine ste_checker #(
    .NUM_LINES  (NUM_LINES),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .pick_any   (pick_any),
    .pop        (pop),
    .grant      (grant),
    .ovf        (ovf),
    .irq        (irq),
    .thresh     (thresh)
);

// File: tb/sig_tstamp_engine_tb_top.sv
// Directed bench for the signal-change timestamp engine, one task per scenario.
module sig_tstamp_engine_tb_top;
    localparam int NS    = 3;
    localparam int NL    = NS * 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] line_in;
    logic [63:0]   sys_time = 64'd0;
    logic          reg_wr, reg_rd;
    logic [5:0]    reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic          irq;
    int            n_tests = 0;
    int            n_fail  = 0;

    always #5 clk = ~clk;
    always @(posedge clk) sys_time <= sys_time + 64'd1;

    sig_tstamp_engine #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .sys_time  (sys_time),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pop_rec(output logic [63:0] ts, output logic [31:0] info);
        logic [31:0] lo, hi;
        rd(2, lo);
        rd(3, hi);
        ts = {hi, lo};
        rd(4, info);
    endtask

    // Applies a new line vector at a falling edge; returns sys_time then.
    task automatic drive(input logic [NL-1:0] v, output logic [63:0] c);
        @(negedge clk);
        line_in = v;
        c = sys_time;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, d);  check("R1 status", d, 32'h2);
        check("R1 irq", irq, 0);
        rd(1, d);  check("R1 thresh", d, 1);
        rd(16, d); check("R1 enable0", d, 0);
        rd(18, d); check("R1 enable2", d, 0);
    endtask

    task automatic t_single();
        logic [63:0] c, ts; logic [31:0] d, info; logic [NL-1:0] v;
        wr(16, 32'h8);
        v = line_in; v[3] = 1'b1; drive(v, c);
        repeat (6) @(negedge clk);
        rd(2, d);
        rd(0, d); check("R8 TS read no pop", d[31:16], 1);
        check("R9 not empty", d[1], 0);
        pop_rec(ts, info);
        check("R2 timestamp", ts, c + 3);
        check("R2 index+valid", {info[31], info[15:0]}, {1'b1, 16'd3});
        check("R3 rise level", info[16], 1);
        v = line_in; v[3] = 1'b0; drive(v, c);
        repeat (6) @(negedge clk);
        pop_rec(ts, info);
        check("R3 fall level", info[16], 0);
        check("R2 fall timestamp", ts, c + 3);
        rd(0, d); check("R9 empty after pop", d, 32'h2);
    endtask

    task automatic t_disabled();
        logic [63:0] c, ts; logic [31:0] d, info; logic [NL-1:0] v;
        v = line_in; v[70] = 1'b1; drive(v, c);
        repeat (8) @(negedge clk);
        rd(0, d); check("R4 disabled line no record", d[31:16], 0);
        wr(18, 32'h40);
        rd(18, d); check("R4 enable readback", d, 32'h40);
        v = line_in; v[70] = 1'b0; drive(v, c);
        repeat (6) @(negedge clk);
        pop_rec(ts, info);
        check("R4 enabled line 70", {info[31], info[16], info[15:0]}, {2'b10, 16'd70});
    endtask

    task automatic t_simul();
        logic [63:0] c, ts; logic [31:0] info; logic [NL-1:0] v;
        wr(16, 32'h28);          // lines 3 and 5; line 6 stays off
        wr(17, 32'h100);         // line 40
        v = line_in; v[5] = 1'b1; v[6] = 1'b1; v[40] = 1'b1; drive(v, c);
        repeat (8) @(negedge clk);
        pop_rec(ts, info);
        check("R5 first index", info[15:0], 5);
        check("R5 first ts", ts, c + 3);
        pop_rec(ts, info);
        check("R5 second index", info[15:0], 40);
        check("R5 second ts", ts, c + 4);
        rd(4, info); check("R4 line 6 masked", info, 0);
    endtask

    task automatic t_thresh();
        logic [63:0] c, ts; logic [31:0] d, info; logic [NL-1:0] v;
        wr(1, 3);      rd(1, d); check("R7 thresh write", d, 3);
        wr(1, 0);      rd(1, d); check("R7 zero ignored", d, 3);
        wr(1, 257);    rd(1, d); check("R7 257 ignored", d, 3);
        wr(17, 32'hF00);
        for (int k = 41; k <= 43; k++) begin
            v = line_in; v[k] = 1'b1; drive(v, c);
            repeat (6) @(negedge clk);
            #1 check("R7 irq vs count", irq, (k == 43));
        end
        rd(0, d); check("R7 status irq bit", d[2], 1);
        pop_rec(ts, info);
        #1 check("R7 irq drops below", irq, 0);
        pop_rec(ts, info);
        pop_rec(ts, info);
        check("R5 third in order", info[15:0], 43);
        wr(1, 256);    rd(1, d); check("R7 256 accepted", d, 256);
        wr(1, 1);
    endtask

    task automatic t_overflow();
        logic [63:0] c, ts; logic [31:0] d, info; logic [NL-1:0] v, lv;
        wr(16, 32'h1FFFF);
        v = line_in; v[16:0] = ~v[16:0]; drive(v, c);
        lv = v;
        repeat (25) @(negedge clk);
        rd(0, d);
        check("R6 count at depth", d[31:16], DEPTH);
        check("R6 overflow set", d[0], 1);
        check("R7 irq full", irq, 1);
        wr(0, 32'h0); rd(0, d); check("R6 write 0 keeps flag", d[0], 1);
        for (int i = 0; i < DEPTH; i++) begin
            pop_rec(ts, info);
            check("R5 overflow order", {info[16], info[15:0]}, {lv[i], 16'(i)});
        end
        rd(4, info); check("R6 last dropped", info, 0);
        wr(0, 32'h1); rd(0, d); check("R6 w1c clears", d, 32'h2);
    endtask

    task automatic t_empty();
        logic [31:0] d;
        rd(4, d); check("R8 empty info", d, 0);
        rd(4, d); check("R8 empty info again", d, 0);
        rd(0, d); check("R8 empty count stays 0", d, 32'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; line_in = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_disabled();
        t_simul();
        t_thresh();
        t_overflow();
        t_empty();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule